// File: doc/BRIEF.md
# Video Frame Transit Latency Meter

This block measures how long each video frame spends inside a streaming processing chain. It watches two AXI4-Stream taps: one where frames enter the chain and one where they leave it. A frame start is recognised on either tap when the start-of-frame user bit is high in a beat that completes a handshake. Each input frame start stores the value of a free-running cycle counter in a small first-in first-out queue of pending timestamps. Each output frame start removes the oldest timestamp and subtracts it from the current counter value. The result is the transit time of that frame in counter ticks.

The block keeps the most recent transit time, the smallest and largest seen since the last clear, and a count of completed frames. It also holds two sticky error flags: one for a queue overflow and one for an output frame start that had no matching input frame. A processor reads all of these values, and the live counter, through an AXI4-Lite slave register file. Once it has been enabled, the block needs no further processor action, so measurement continues even if the software stops responding. At a 100 MHz clock, one tick is 10 ns.

Top module: `vid_latency_meter`

## Requirements
- R1: The time base counter is CNT_W bits wide. It resets to 0, increases by one every clock cycle whatever the other settings, wraps modulo 2^CNT_W, and reads zero-extended at byte offset 0x08. The value returned is the count at the clock edge where the read address is accepted.
- R2: Control register at offset 0x00: bit 0 is the measurement enable, which resets to 0 and reads back as written. While the enable is 0, frame starts on both taps are ignored. They change no statistic and no flag.
- R3: An input frame start is a cycle with in_tvalid, in_tready and in_tuser[0] all high. It pushes the counter value into a pending queue of DEPTH entries. If the queue is full and no pop happens in the same cycle, the timestamp is dropped and status bit 0 (overflow) is set and stays set.
- R4: An output frame start (out_tvalid, out_tready and out_tuser[0] all high) pops the oldest pending timestamp, in first-in first-out order. The latency is the current counter minus that timestamp, modulo 2^CNT_W, so a counter wrap in between still gives the true tick count.
- R5: Each recorded latency updates four registers at once. Offset 0x0C holds the last latency. Offset 0x10 holds the minimum, which resets to all ones in the CNT_W width. Offset 0x14 holds the maximum, which resets to 0. Offset 0x18 holds the completed-frame count, which resets to 0.
- R6: An output frame start with the queue empty sets status bit 1 (underflow), which stays set. No latency is recorded in that case.
- R7: Status register at offset 0x04 is write-1-to-clear, bit by bit. Writing 0 to a bit leaves it unchanged. A new error event in the same cycle as a clear wins over the clear.
- R8: Writing 1 to control bit 1 resets minimum, maximum and frame count to their reset values. The bit triggers a single action and always reads back as 0. The enable bit is written by the same access.
- R9: AXI4-Lite reads complete with OKAY one cycle after the address handshake. The data stays stable while rready is low. Offsets with no register read as 0. Writes apply only when write strobe bit 0 is set, and they always answer with OKAY.
- R10: An input and an output frame start in the same cycle both take effect. This holds even when the queue is full, because the pop frees a slot for the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer tick |
| rst_n | input | 1 | Synchronous active-low reset |
| in_tvalid | input | 1 | Input tap stream valid |
| in_tready | input | 1 | Input tap stream ready |
| in_tuser | input | USER_W | Input tap user bits, bit 0 marks frame start |
| out_tvalid | input | 1 | Output tap stream valid |
| out_tready | input | 1 | Output tap stream ready |
| out_tuser | input | USER_W | Output tap user bits, bit 0 marks frame start |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The bench builds the block with CNT_W set to 12 and DEPTH left at 4. With a 12-bit counter, the time base wraps every 4096 cycles. Two back-to-back 3000-tick measurements therefore cannot both avoid a wrap, so the modulo subtraction is tested within a few thousand cycles. With a queue of four entries, both the overflow and the full-queue simultaneous push-and-pop cases can be reached with short patterns of one-cycle frame starts. Uneven output spacing makes first-in first-out ordering give latencies that differ from any other ordering.

// File: rtl/vlm_pkg.sv
// Shared constants of the frame latency meter: register word indices,
// status bit positions and AXI response codes.
package vlm_pkg;
    localparam int REG_W = 32;

    // Word index of each register (byte offset divided by four).
    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_STATUS = 3'd1;
    localparam logic [2:0] IDX_TIMER  = 3'd2;
    localparam logic [2:0] IDX_LAST   = 3'd3;
    localparam logic [2:0] IDX_MIN    = 3'd4;
    localparam logic [2:0] IDX_MAX    = 3'd5;
    localparam logic [2:0] IDX_FRAMES = 3'd6;

    // Bit positions inside control and status.
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int STAT_OVF_BIT = 0;
    localparam int STAT_UNF_BIT = 1;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Identifies which tap a frame-start detector watches.
    typedef enum logic {
        TAP_IN  = 1'b0,
        TAP_OUT = 1'b1
    } tap_e;
endpackage

// File: rtl/vlm_sof_detect.sv
// Frame-start detector for one AXI4-Stream tap.
// Produces a single-cycle strobe when a handshake beat carries the
// start-of-frame user bit (bit 0) and measurement is enabled.
// Assumes the tap signals are synchronous to clk; no state is held.
module vlm_sof_detect #(
    parameter int USER_W = 1
) (
    input  logic              enable,
    input  logic              tvalid,
    input  logic              tready,
    input  logic [USER_W-1:0] tuser,
    output logic              sof
);
    // Purpose: a completed beat flagged as the first of a frame.
    always_comb begin
        sof = enable & tvalid & tready & tuser[0];
    end

    if (USER_W > 1) begin : g_unused_user
        logic unused_user;
        // Purpose: upper user bits carry no meaning here.
        assign unused_user = ^tuser[USER_W-1:1];
    end
endmodule

// File: rtl/vlm_ts_fifo.sv
// Pending-timestamp queue: first-in first-out storage of DEPTH words.
// The owner decides when a push or pop is legal; this module only
// requires that pop is never raised while empty, and push never while
// full unless pop is raised in the same cycle. DEPTH is a power of two.
module vlm_ts_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic [W-1:0]             din,
    output logic [W-1:0]             dout,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] fill;

    // Purpose: expose occupancy and the head entry.
    always_comb begin
        full  = (fill == LVL_W'(DEPTH));
        empty = (fill == '0);
        level = fill;
        dout  = mem[rd_ptr];
    end

    // Purpose: store pushed words at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Purpose: advance pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/vlm_stats.sv
// Latency statistics: last, minimum, maximum and completed-frame count.
// A clear request restores the reset values of minimum, maximum and
// count and takes priority over a sample arriving in the same cycle;
// the last-latency register still takes that sample.
module vlm_stats #(
    parameter int W       = 32,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               rec,
    input  logic [W-1:0]       lat,
    output logic [W-1:0]       last_lat,
    output logic [W-1:0]       min_lat,
    output logic [W-1:0]       max_lat,
    output logic [FRAME_W-1:0] frames
);
    // Purpose: hold the most recent latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lat <= '0;
        end else if (rec) begin
            last_lat <= lat;
        end
    end

    // Purpose: running extremes and frame count, with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            min_lat <= '1;
            max_lat <= '0;
            frames  <= '0;
        end else if (rec) begin
            if (lat < min_lat) min_lat <= lat;
            if (lat > max_lat) max_lat <= lat;
            frames <= frames + 1'b1;
        end
    end
endmodule

// File: rtl/vlm_axil_regs.sv
// AXI4-Lite slave register file of the latency meter.
// Accepts a write when address and data are both valid and no response
// is pending; accepts a read when no read data is pending. Read data is
// registered, so it follows the address handshake by one cycle.
// Holds the control enable and the sticky error flags.
module vlm_axil_regs #(
    parameter int ADDR_W  = 5,
    parameter int CNT_W   = 32,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic [3:0]         s_wstrb,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    input  logic [CNT_W-1:0]   timer,
    input  logic [CNT_W-1:0]   last_lat,
    input  logic [CNT_W-1:0]   min_lat,
    input  logic [CNT_W-1:0]   max_lat,
    input  logic [FRAME_W-1:0] frames,
    input  logic               ovf_evt,
    input  logic               unf_evt,
    output logic               enable,
    output logic               stats_clr,
    output logic               ovf_flag,
    output logic               unf_flag
);
    import vlm_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic             wr_fire;
    logic             rd_fire;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_ctrl;
    logic             wr_stat;
    logic [31:0]      rd_mux;

    // Purpose: handshake decode and register selection.
    always_comb begin
        wr_fire   = s_awvalid & s_wvalid & ~s_bvalid;
        s_awready = wr_fire;
        s_wready  = wr_fire;
        rd_fire   = s_arvalid & ~s_rvalid;
        s_arready = ~s_rvalid;
        wr_idx    = s_awaddr[ADDR_W-1:2];
        rd_idx    = s_araddr[ADDR_W-1:2];
        wr_ctrl   = wr_fire & s_wstrb[0] & (wr_idx == IDX_W'(IDX_CTRL));
        wr_stat   = wr_fire & s_wstrb[0] & (wr_idx == IDX_W'(IDX_STATUS));
        stats_clr = wr_ctrl & s_wdata[CTRL_CLR_BIT];
        s_bresp   = RESP_OKAY;
        s_rresp   = RESP_OKAY;
    end

    // Purpose: read data selection, zero-extending narrow values.
    always_comb begin
        rd_mux = '0;
        case (rd_idx)
            IDX_W'(IDX_CTRL):   rd_mux[CTRL_EN_BIT] = enable;
            IDX_W'(IDX_STATUS): begin
                rd_mux[STAT_OVF_BIT] = ovf_flag;
                rd_mux[STAT_UNF_BIT] = unf_flag;
            end
            IDX_W'(IDX_TIMER):  rd_mux = 32'(timer);
            IDX_W'(IDX_LAST):   rd_mux = 32'(last_lat);
            IDX_W'(IDX_MIN):    rd_mux = 32'(min_lat);
            IDX_W'(IDX_MAX):    rd_mux = 32'(max_lat);
            IDX_W'(IDX_FRAMES): rd_mux = 32'(frames);
            default:            rd_mux = '0;
        endcase
    end

    // Purpose: enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (wr_ctrl) begin
            enable <= s_wdata[CTRL_EN_BIT];
        end
    end

    // Purpose: sticky error flags, set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt | (ovf_flag & ~(wr_stat & s_wdata[STAT_OVF_BIT]));
            unf_flag <= unf_evt | (unf_flag & ~(wr_stat & s_wdata[STAT_UNF_BIT]));
        end
    end

    // Purpose: write response channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_bvalid <= 1'b0;
        end else if (wr_fire) begin
            s_bvalid <= 1'b1;
        end else if (s_bready) begin
            s_bvalid <= 1'b0;
        end
    end

    // Purpose: read data channel with registered data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rd_fire) begin
            s_rvalid <= 1'b1;
            s_rdata  <= rd_mux;
        end else if (s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    logic unused_bits;
    // Purpose: sink for address and data bits with no function.
    assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wstrb[3:1],
                           s_wdata[31:2]};
endmodule

// File: rtl/vid_latency_meter.sv
// Video frame transit latency meter (top).
// Runs a free-running CNT_W-bit time base, pairs frame starts seen on
// an input and an output AXI4-Stream tap through a DEPTH-entry queue
// of pending timestamps, and publishes statistics on AXI4-Lite.
// Assumes one clock domain for taps and bus; CNT_W <= 32; ADDR_W >= 5.
module vid_latency_meter #(
    parameter int CNT_W   = 32,
    parameter int DEPTH   = 4,
    parameter int USER_W  = 1,
    parameter int ADDR_W  = 5,
    parameter int FRAME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_tvalid,
    input  logic              in_tready,
    input  logic [USER_W-1:0] in_tuser,
    input  logic              out_tvalid,
    input  logic              out_tready,
    input  logic [USER_W-1:0] out_tuser,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);
    import vlm_pkg::*;

    localparam int LVL_W  = $clog2(DEPTH) + 1;
    localparam int N_TAPS = 2;

    logic [CNT_W-1:0]   timer;
    logic               enable;
    logic               stats_clr;
    logic               ovf_flag;
    logic               unf_flag;
    logic [N_TAPS-1:0]  tap_valid;
    logic [N_TAPS-1:0]  tap_ready;
    logic [USER_W-1:0]  tap_user [N_TAPS];
    logic [N_TAPS-1:0]  tap_sof;
    logic               in_sof;
    logic               out_sof;
    logic               q_push;
    logic               q_pop;
    logic               q_full;
    logic               q_empty;
    logic [CNT_W-1:0]   q_head;
    logic [LVL_W-1:0]   q_level;
    logic [CNT_W-1:0]   latency;
    logic               ovf_evt;
    logic               unf_evt;
    logic [CNT_W-1:0]   last_lat;
    logic [CNT_W-1:0]   min_lat;
    logic [CNT_W-1:0]   max_lat;
    logic [FRAME_W-1:0] frames;

    // Purpose: free-running time base, wraps modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer <= '0;
        end else begin
            timer <= timer + 1'b1;
        end
    end

    // Purpose: gather both taps into indexed arrays.
    always_comb begin
        tap_valid[TAP_IN]  = in_tvalid;
        tap_ready[TAP_IN]  = in_tready;
        tap_user[TAP_IN]   = in_tuser;
        tap_valid[TAP_OUT] = out_tvalid;
        tap_ready[TAP_OUT] = out_tready;
        tap_user[TAP_OUT]  = out_tuser;
    end

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        vlm_sof_detect #(.USER_W(USER_W)) u_sof (
            .enable (enable),
            .tvalid (tap_valid[t]),
            .tready (tap_ready[t]),
            .tuser  (tap_user[t]),
            .sof    (tap_sof[t])
        );
    end

    // Purpose: queue control, latency and error events.
    always_comb begin
        in_sof  = tap_sof[TAP_IN];
        out_sof = tap_sof[TAP_OUT];
        q_pop   = out_sof & ~q_empty;
        q_push  = in_sof & (~q_full | q_pop);
        ovf_evt = in_sof & q_full & ~q_pop;
        unf_evt = out_sof & q_empty;
        latency = timer - q_head;
    end

    vlm_ts_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (q_pop),
        .din   (timer),
        .dout  (q_head),
        .full  (q_full),
        .empty (q_empty),
        .level (q_level)
    );

    vlm_stats #(.W(CNT_W), .FRAME_W(FRAME_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stats_clr),
        .rec      (q_pop),
        .lat      (latency),
        .last_lat (last_lat),
        .min_lat  (min_lat),
        .max_lat  (max_lat),
        .frames   (frames)
    );

    vlm_axil_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .timer     (timer),
        .last_lat  (last_lat),
        .min_lat   (min_lat),
        .max_lat   (max_lat),
        .frames    (frames),
        .ovf_evt   (ovf_evt),
        .unf_evt   (unf_evt),
        .enable    (enable),
        .stats_clr (stats_clr),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );
endmodule

// File: rtl/vlm_checker.sv
// Property checker for the latency meter, bound into every instance.
// Observes the time base, queue occupancy, error flags, statistics and
// bus channels; drives nothing.
module vlm_checker #(
    parameter int CNT_W   = 32,
    parameter int DEPTH   = 4,
    parameter int FRAME_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CNT_W-1:0]         timer,
    input logic [$clog2(DEPTH):0]   q_level,
    input logic                     q_full,
    input logic                     q_empty,
    input logic                     in_sof,
    input logic                     out_sof,
    input logic                     ovf_flag,
    input logic                     unf_flag,
    input logic [CNT_W-1:0]         min_lat,
    input logic [CNT_W-1:0]         max_lat,
    input logic [FRAME_W-1:0]       frames,
    input logic                     s_rvalid,
    input logic                     s_rready,
    input logic [31:0]              s_rdata,
    input logic                     s_bvalid,
    input logic                     s_bready
);
    // R1: the time base advances by exactly one each cycle.
    a_r1_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (timer - $past(timer)) == CNT_W'(1));

    // R3: the queue never holds more than DEPTH timestamps.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= ($clog2(DEPTH) + 1)'(DEPTH));

    // R3: a dropped input frame start raises the overflow flag.
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sof && q_full && !out_sof) |=> ovf_flag);

    // R6: an unmatched output frame start raises the underflow flag.
    a_r6_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && q_empty) |=> unf_flag);

    // R5: with any frame recorded, the minimum never exceeds the maximum.
    a_r5_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        (frames != '0) |-> (min_lat <= max_lat));

    // R9: read data is held until accepted.
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    // R9: a write response is held until accepted.
    a_r9_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);
endmodule

bind vid_latency_meter vlm_checker #(
    .CNT_W   (CNT_W),
    .DEPTH   (DEPTH),
    .FRAME_W (FRAME_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .timer    (timer),
    .q_level  (q_level),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .in_sof   (in_sof),
    .out_sof  (out_sof),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag),
    .min_lat  (min_lat),
    .max_lat  (max_lat),
    .frames   (frames),
    .s_rvalid (s_rvalid),
    .s_rready (s_rready),
    .s_rdata  (s_rdata),
    .s_bvalid (s_bvalid),
    .s_bready (s_bready)
);

// File: tb/vid_latency_meter_tb.sv
`timescale 1ns/1ps
// Directed bench for the latency meter, built with a 12-bit time base.
module vid_latency_meter_tb;
    localparam int CNT_W  = 12;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 5;
    localparam logic [31:0] MIN_RST = 32'h0000_0FFF;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_TIMER = 5'h08,
        A_LAST = 5'h0C, A_MIN = 5'h10, A_MAX = 5'h14, A_FRAMES = 5'h18, A_HOLE = 5'h1C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_tvalid = 0, in_tready = 0, out_tvalid = 0, out_tready = 0;
    logic [0:0] in_tuser = '0, out_tuser = '0;
    logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0;
    logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
    logic s_bready = 1, s_rready = 1;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [31:0] s_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vid_latency_meter #(.CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tuser(in_tuser),
        .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tuser(out_tuser),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write; the handshake edge is the first posedge after the drive.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic [3:0] strb = 4'hF);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = strb;
        s_awvalid = 1; s_wvalid = 1;
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        check("R9 bresp", {31'd0, s_bvalid}, 32'd1);
        check("R9 bresp code", {30'd0, s_bresp}, 32'd0);
    endtask

    // One read; data sampled at the negedge after the address handshake.
    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1;
        @(negedge clk);
        s_arvalid = 0;
        check("R9 rvalid", {31'd0, s_rvalid}, 32'd1);
        check("R9 rresp", {30'd0, s_rresp}, 32'd0);
        d = s_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [ADDR_W-1:0] a,
                              input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    // Drive frame starts: bit i of each pattern is sampled at edge i.
    task automatic run_pattern(input logic [31:0] ip, input logic [31:0] op, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_tvalid = ip[i]; in_tready = ip[i]; in_tuser = ip[i];
            out_tvalid = op[i]; out_tready = op[i]; out_tuser = op[i];
        end
        @(negedge clk);
        in_tvalid = 0; in_tready = 0; in_tuser = 0;
        out_tvalid = 0; out_tready = 0; out_tuser = 0;
    endtask

    // One input frame start followed by an output one k ticks later.
    task automatic frame_pair(input int k);
        @(negedge clk);
        in_tvalid = 1; in_tready = 1; in_tuser = 1;
        @(negedge clk);
        in_tvalid = 0; in_tready = 0; in_tuser = 0;
        repeat (k - 1) @(negedge clk);
        out_tvalid = 1; out_tready = 1; out_tuser = 1;
        @(negedge clk);
        out_tvalid = 0; out_tready = 0; out_tuser = 0;
    endtask

    task automatic t_reset;
        expect_reg("R2 enable at reset", A_CTRL, 32'd0);
        expect_reg("R7 status at reset", A_STAT, 32'd0);
        expect_reg("R5 last at reset", A_LAST, 32'd0);
        expect_reg("R5 min at reset", A_MIN, MIN_RST);
        expect_reg("R5 max at reset", A_MAX, 32'd0);
        expect_reg("R5 count at reset", A_FRAMES, 32'd0);
    endtask

    task automatic t_timer;
        logic [31:0] a, b;
        bus_read(A_TIMER, a);
        bus_read(A_TIMER, b);
        check("R1 timer step between reads", (b - a) & 32'hFFF, 32'd2);
        check("R1 timer width", b & 32'hFFFF_F000, 32'd0);
    endtask

    task automatic t_disabled;
        run_pattern(32'h1, 32'h20, 6);
        expect_reg("R2 no flag while disabled", A_STAT, 32'd0);
        expect_reg("R2 no frame while disabled", A_FRAMES, 32'd0);
    endtask

    task automatic t_order;
        bus_write(A_CTRL, 32'h1);
        expect_reg("R2 enable readback", A_CTRL, 32'h1);
        // inputs at 0,1,2; outputs at 10,12,14 -> 10, 11, 12
        run_pattern(32'h0000_0007, 32'h0000_5400, 15);
        expect_reg("R4 r5_last in order", A_LAST, 32'd12);
        expect_reg("R4 r5_min in order", A_MIN, 32'd10);
        expect_reg("R5 max", A_MAX, 32'd12);
        expect_reg("R5 count", A_FRAMES, 32'd3);
    endtask

    task automatic t_clear;
        bus_write(A_CTRL, 32'h3);
        expect_reg("R8 clear bit reads 0", A_CTRL, 32'h1);
        expect_reg("R8 min cleared", A_MIN, MIN_RST);
        expect_reg("R8 max cleared", A_MAX, 32'd0);
        expect_reg("R8 count cleared", A_FRAMES, 32'd0);
        expect_reg("R8 last kept", A_LAST, 32'd12);
    endtask

    task automatic t_underflow_w1c;
        run_pattern(32'h0, 32'h1, 1);
        expect_reg("R6 underflow flag", A_STAT, 32'h2);
        expect_reg("R6 no frame recorded", A_FRAMES, 32'd0);
        expect_reg("R6 last unchanged", A_LAST, 32'd12);
        bus_write(A_STAT, 32'h0);
        expect_reg("R7 write 0 keeps flag", A_STAT, 32'h2);
        bus_write(A_STAT, 32'h2, 4'h0);
        expect_reg("R9 strobe 0 ignored", A_STAT, 32'h2);
        bus_write(A_STAT, 32'h2);
        expect_reg("R7 write 1 clears", A_STAT, 32'h0);
    endtask

    task automatic t_overflow;
        // inputs at 0..4 (fifth dropped); outputs at 8..11 -> 8 each
        run_pattern(32'h0000_001F, 32'h0000_0F00, 12);
        expect_reg("R3 overflow flag", A_STAT, 32'h1);
        expect_reg("R3 four frames kept", A_FRAMES, 32'd4);
        expect_reg("R3 min latency", A_MIN, 32'd8);
        expect_reg("R3 max latency", A_MAX, 32'd8);
        run_pattern(32'h0, 32'h1, 1);
        expect_reg("R3 r6 both flags", A_STAT, 32'h3);
        bus_write(A_STAT, 32'h1);
        expect_reg("R7 clear only bit 0", A_STAT, 32'h2);
        bus_write(A_STAT, 32'h3);
        expect_reg("R7 all clear", A_STAT, 32'h0);
    endtask

    task automatic t_simultaneous;
        bus_write(A_CTRL, 32'h3);
        // inputs 0..4, output at 4 (full queue) then 6..9
        run_pattern(32'h0000_001F, 32'h0000_03D0, 10);
        expect_reg("R10 no overflow", A_STAT, 32'h0);
        expect_reg("R10 five frames", A_FRAMES, 32'd5);
        expect_reg("R10 min", A_MIN, 32'd4);
        expect_reg("R10 max", A_MAX, 32'd5);
    endtask

    task automatic t_wrap;
        bus_write(A_CTRL, 32'h3);
        frame_pair(3000);
        expect_reg("R4 long latency", A_LAST, 32'd3000);
        frame_pair(3000);
        expect_reg("R4 latency across wrap", A_LAST, 32'd3000);
        expect_reg("R4 wrap min", A_MIN, 32'd3000);
        expect_reg("R4 wrap max", A_MAX, 32'd3000);
        expect_reg("R9 unmapped reads 0", A_HOLE, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_timer();
        t_disabled();
        t_order();
        t_clear();
        t_underflow_w1c();
        t_overflow();
        t_simultaneous();
        t_wrap();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule